// File: doc/BRIEF.md
# Dual-Standard FSK Tone Synthesizer

This block generates the transmit carrier of a 300-baud frequency-shift-keyed modem as a stream of signed sine samples. It covers two standards, the Bell 103 plan and the V.21 plan. A numerically controlled oscillator runs from the reference clock, nominally 3.579545 MHz. It advances a 24-bit phase accumulator once per sample strobe, which is the reference divided by 46, about 77.8 kHz. The top bits of the accumulator address a quarter-wave-symmetric sine table.

The transmit frequency is set by the standard, the originate/answer role and the data bit. A mode decoder resolves the squelch, loopback and echo-tone controls into one operating state. The states are data, echo tone, loopback, muted and sleep. The block also reports which channel's frequency pair the companion demodulator must listen to. That pair is the opposite channel in normal use and the block's own transmit channel in loopback. All frequencies scale with the reference clock.

Top module: `fsk_tone_synth`

## Requirements
- R1: The transmit frequency is set by `std_v21_i` (0 = Bell 103, 1 = V.21), `orig_i` (1 = originate/channel 1, 0 = answer/channel 2) and `tx_data_i` (1 = mark, 0 = space). Bell originate uses space 1070 Hz and mark 1270 Hz. Bell answer uses space 2025 Hz and mark 2225 Hz. V.21 channel 1 uses mark 980 Hz and space 1180 Hz. V.21 channel 2 uses mark 1650 Hz and space 1850 Hz.
- R2: Each frequency f has a phase increment of round(f * 2^24 * 46 / 3579545), which is within 5 Hz of nominal. On every sample strobe the accumulator adds the increment of the current state. The sample issued at that strobe is round(511 * sin(2*pi*(p + 0.5)/256)), give or take 1 LSB. Here p is accumulator bits [23:16] before the addition.
- R3: `sample_valid_o` is a one-cycle pulse once every 46 clock cycles. After reset release, or after leaving sleep, it is first high in the cycle that follows the 46th rising edge.
- R4: A change of data bit, standard or role does not reset the accumulator, so the output phase is continuous.
- R5: When `echo_i` = 1 and `squelch_i` = `loopback_i` = 0, the tone is fixed at 2100 Hz for V.21 and 2225 Hz for Bell 103. The role and data inputs do not change it.
- R6: When `squelch_i` = 1 and `loopback_i` = 0, every issued sample is 0 (mid-scale) and strobes continue. The accumulator holds its value, so the tone resumes from the frozen phase.
- R7: `rx_ch1_o` = 1 tells the demodulator to use the channel-1 (originate transmit) pair. Outside loopback it equals the inverse of `orig_i`. It is registered and so follows the inputs one clock later.
- R8: When `loopback_i` = 1 and `squelch_i` = 0, `rx_ch1_o` equals `orig_i`. Data transmission continues unchanged, and loopback takes priority over `echo_i`.
- R9: When `loopback_i` = 1 and `squelch_i` = 1, the block sleeps. No strobe is issued, `sample_o` is 0 and the accumulator holds its value.
- R10: During reset `sample_o` is 0, `sample_valid_o` is 0, `rx_ch1_o` is 0 and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 1 | Data bit, 1 = mark |
| std_v21_i | input | 1 | Standard select, 1 = V.21, 0 = Bell 103 |
| orig_i | input | 1 | 1 = originate / channel 1, 0 = answer / channel 2 |
| squelch_i | input | 1 | Transmit squelch |
| loopback_i | input | 1 | Analog loopback request |
| echo_i | input | 1 | Echo tone request |
| sample_o | output | 10 | Signed sine sample |
| sample_valid_o | output | 1 | Sample strobe, one cycle |
| rx_ch1_o | output | 1 | Demodulator pair select, 1 = channel-1 pair |

## Verification
A sample leaves the block one cycle after its strobe edge, and the strobe recurs every 46 clocks. The bench therefore changes inputs only on the falling edge just after a valid pulse. This guarantees that the next strobe sees the new setting. The bench keeps its own model of the accumulator, advanced at each observed valid with the increment of the inputs it holds, and compares each sample against its sine. `rx_ch1_o` is registered once, so it is checked two falling edges after an input change, and the sleep exit is checked by counting exactly 46 edges to the first valid.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic [2:0] {
    ST_DATA,
    ST_ECHO,
    ST_LOOP,
    ST_MUTE,
    ST_SLEEP
  } op_state_e;

  // nominal tone frequencies in Hz
  localparam int HZ_BELL_LO_SPACE = 1070;
  localparam int HZ_BELL_LO_MARK  = 1270;
  localparam int HZ_BELL_HI_SPACE = 2025;
  localparam int HZ_BELL_HI_MARK  = 2225;
  localparam int HZ_V21_C1_MARK   = 980;
  localparam int HZ_V21_C1_SPACE  = 1180;
  localparam int HZ_V21_C2_MARK   = 1650;
  localparam int HZ_V21_C2_SPACE  = 1850;
  localparam int HZ_ECHO_V21      = 2100;
  localparam int HZ_ECHO_BELL     = 2225;

  function automatic longint tone_inc(input longint hz, input longint ref_hz,
                                      input longint div, input int acc_w);
    return ((hz <<< acc_w) * div + ref_hz / 2) / ref_hz;
  endfunction

  // quarter-wave sine magnitude at (j+0.5)/2^lut_aw of a turn, Taylor series in Q30
  function automatic int quarter_sine(input int j, input int lut_aw, input int amp_w);
    longint x, x2, term, sum, amp;
    x = (longint'(2 * j + 1) * 64'sd3373259426) >>> lut_aw;
    x2 = (x * x) >>> 30;
    term = x;
    sum = x;
    for (int n = 1; n <= 5; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum = sum + term;
    end
    amp = (longint'(1) <<< (amp_w - 1)) - 1;
    return int'((sum * amp + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/fsk_mode_dec.sv
module fsk_mode_dec
  import fsk_pkg::*;
(
  input  logic      squelch_i,
  input  logic      loopback_i,
  input  logic      echo_i,
  output op_state_e state_o
);

  // sleep > mute > loop > echo > data
  always_comb begin
    if (loopback_i && squelch_i) state_o = ST_SLEEP;
    else if (squelch_i)          state_o = ST_MUTE;
    else if (loopback_i)         state_o = ST_LOOP;
    else if (echo_i)             state_o = ST_ECHO;
    else                         state_o = ST_DATA;
  end

endmodule

// File: rtl/fsk_inc_sel.sv
module fsk_inc_sel
  import fsk_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int REF_HZ     = 3579545,
  parameter int SAMPLE_DIV = 46
) (
  input  logic             std_v21_i,
  input  logic             orig_i,
  input  logic             mark_i,
  input  op_state_e        state_i,
  output logic [ACC_W-1:0] inc_o
);

  localparam logic [ACC_W-1:0] I_BL_S = ACC_W'(tone_inc(HZ_BELL_LO_SPACE, REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_BL_M = ACC_W'(tone_inc(HZ_BELL_LO_MARK,  REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_BH_S = ACC_W'(tone_inc(HZ_BELL_HI_SPACE, REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_BH_M = ACC_W'(tone_inc(HZ_BELL_HI_MARK,  REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_V1_M = ACC_W'(tone_inc(HZ_V21_C1_MARK,   REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_V1_S = ACC_W'(tone_inc(HZ_V21_C1_SPACE,  REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_V2_M = ACC_W'(tone_inc(HZ_V21_C2_MARK,   REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_V2_S = ACC_W'(tone_inc(HZ_V21_C2_SPACE,  REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_EC_V = ACC_W'(tone_inc(HZ_ECHO_V21,      REF_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] I_EC_B = ACC_W'(tone_inc(HZ_ECHO_BELL,     REF_HZ, SAMPLE_DIV, ACC_W));

  logic [ACC_W-1:0] data_inc;

  always_comb begin
    unique case ({std_v21_i, orig_i, mark_i})
      3'b010:  data_inc = I_BL_S;
      3'b011:  data_inc = I_BL_M;
      3'b000:  data_inc = I_BH_S;
      3'b001:  data_inc = I_BH_M;
      3'b111:  data_inc = I_V1_M;
      3'b110:  data_inc = I_V1_S;
      3'b101:  data_inc = I_V2_M;
      default: data_inc = I_V2_S;
    endcase
  end

  always_comb begin
    if (state_i == ST_ECHO) inc_o = std_v21_i ? I_EC_V : I_EC_B;
    else                    inc_o = data_inc;
  end

endmodule

// File: rtl/fsk_nco.sv
module fsk_nco
  import fsk_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int SAMPLE_DIV = 46,
  parameter int LUT_AW     = 8,
  parameter int AMP_W      = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    mute_i,
  input  logic [ACC_W-1:0]        inc_i,
  output logic signed [AMP_W-1:0] sample_o,
  output logic                    valid_o
);

  localparam int CNT_W = $clog2(SAMPLE_DIV);
  localparam int QN    = 2 ** (LUT_AW - 2);
  localparam int QW    = AMP_W - 1;

  logic [CNT_W-1:0]        div_q;
  logic                    strobe;
  logic [ACC_W-1:0]        acc_q;
  logic [QW-1:0]           qtab [QN];
  logic [LUT_AW-1:0]       idx;
  logic [LUT_AW-3:0]       qidx;
  logic signed [AMP_W-1:0] mag, val;

  for (genvar g = 0; g < QN; g++) begin : g_qtab
    assign qtab[g] = QW'(quarter_sine(g, LUT_AW, AMP_W));
  end

  assign strobe = run_i && (div_q == CNT_W'(SAMPLE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else if (strobe) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // phase advances only on a live strobe, never resets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (strobe && !mute_i) acc_q <= acc_q + inc_i;
  end

  assign idx  = acc_q[ACC_W-1 -: LUT_AW];
  assign qidx = idx[LUT_AW-2] ? ~idx[LUT_AW-3:0] : idx[LUT_AW-3:0];
  assign mag  = $signed({1'b0, qtab[qidx]});
  assign val  = idx[LUT_AW-1] ? -mag : mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= strobe;
      if (!run_i)      sample_o <= '0;
      else if (strobe) sample_o <= mute_i ? '0 : val;
    end
  end

  AST_ACC_ONLY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(acc_q)); // R4
  AST_MUTE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && mute_i) |=> (acc_q == $past(acc_q) && sample_o == '0)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R3
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!valid_o && sample_o == '0)); // R9

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int REF_HZ     = 3579545,
  parameter int SAMPLE_DIV = 46,
  parameter int LUT_AW     = 8,
  parameter int AMP_W      = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tx_data_i,
  input  logic                    std_v21_i,
  input  logic                    orig_i,
  input  logic                    squelch_i,
  input  logic                    loopback_i,
  input  logic                    echo_i,
  output logic signed [AMP_W-1:0] sample_o,
  output logic                    sample_valid_o,
  output logic                    rx_ch1_o
);

  op_state_e        state;
  logic [ACC_W-1:0] inc;

  fsk_mode_dec i_mode_dec (
    .squelch_i  (squelch_i),
    .loopback_i (loopback_i),
    .echo_i     (echo_i),
    .state_o    (state)
  );

  fsk_inc_sel #(
    .ACC_W      (ACC_W),
    .REF_HZ     (REF_HZ),
    .SAMPLE_DIV (SAMPLE_DIV)
  ) i_inc_sel (
    .std_v21_i (std_v21_i),
    .orig_i    (orig_i),
    .mark_i    (tx_data_i),
    .state_i   (state),
    .inc_o     (inc)
  );

  fsk_nco #(
    .ACC_W      (ACC_W),
    .SAMPLE_DIV (SAMPLE_DIV),
    .LUT_AW     (LUT_AW),
    .AMP_W      (AMP_W)
  ) i_nco (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state != ST_SLEEP),
    .mute_i   (state == ST_MUTE),
    .inc_i    (inc),
    .sample_o (sample_o),
    .valid_o  (sample_valid_o)
  );

  // demodulator listens to the far channel, or to itself in loopback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_ch1_o <= 1'b0;
    else         rx_ch1_o <= (state == ST_LOOP) ? orig_i : ~orig_i;
  end

  AST_LOOP_RX_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOOP) |=> (rx_ch1_o == $past(orig_i))); // R8
  AST_RX_FAR_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA || state == ST_ECHO) |=> (rx_ch1_o != $past(orig_i))); // R7

endmodule

// File: tb/test_fsk_tone_synth.sv
module test_fsk_tone_synth;

  localparam int DIV = 46;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_data = 1'b0, std_v21 = 1'b0, orig = 1'b1;
  logic squelch = 1'b0, loopback = 1'b0, echo = 1'b0;
  logic signed [9:0] sample;
  logic valid, rx_ch1;

  int checks = 0;
  int errors = 0;
  logic [23:0] acc_m = '0;

  always #10 clk = ~clk;

  fsk_tone_synth i_fsk_tone_synth (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .tx_data_i      (tx_data),
    .std_v21_i      (std_v21),
    .orig_i         (orig),
    .squelch_i      (squelch),
    .loopback_i     (loopback),
    .echo_i         (echo),
    .sample_o       (sample),
    .sample_valid_o (valid),
    .rx_ch1_o       (rx_ch1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic int model_hz();
    if (echo && !loopback) return std_v21 ? 2100 : 2225;
    if (!std_v21) begin
      if (orig) return tx_data ? 1270 : 1070;
      else      return tx_data ? 2225 : 2025;
    end else begin
      if (orig) return tx_data ? 980 : 1180;
      else      return tx_data ? 1650 : 1850;
    end
  endfunction

  function automatic int model_sine(input logic [7:0] p);
    real v;
    v = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic wait_valid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!valid && gap < 400);
  endtask

  // n samples: check spacing (R3) and value (R2, or 0 when muted R6)
  task automatic run_samples(input int n, input string req, input bit check_gap);
    for (int k = 0; k < n; k++) begin
      int gap, exp, d;
      wait_valid(gap);
      if (check_gap || k > 0) chk("R3 spacing", gap, DIV);
      if (squelch) begin
        chk({req, " R6 muted sample"}, sample, 0);
      end else begin
        exp = model_sine(acc_m[23:16]);
        d = int'(sample) - exp;
        checks++;
        if (d > 1 || d < -1) begin
          errors++;
          $display("FAIL %s R2 sample actual=%0d expected=%0d", req, sample, exp);
        end
        acc_m = acc_m + 24'($rtoi(real'(model_hz()) * 16777216.0 * 46.0 / 3579545.0 + 0.5));
      end
    end
  endtask

  task automatic t_reset;
    int gap;
    chk("R10 sample in reset", sample, 0);
    chk("R10 valid in reset", valid, 0);
    chk("R10 rx in reset", rx_ch1, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    wait_valid(gap);
    chk("R3 first valid edge", gap, DIV);
    chk("R2 first sample at phase 0", sample, model_sine(8'd0));
    acc_m = acc_m + 24'($rtoi(real'(model_hz()) * 16777216.0 * 46.0 / 3579545.0 + 0.5));
  endtask

  task automatic t_tx_table;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int d = 0; d < 2; d++) begin
          std_v21 = s[0]; orig = o[0]; tx_data = d[0];
          run_samples(12, "R1 tone table", 1'b1);
          @(negedge clk); @(negedge clk);
          chk("R7 rx pair far channel", rx_ch1, int'(!orig));
          wait_valid_sync();
        end
  endtask

  // realign so inputs keep changing just after a valid
  task automatic wait_valid_sync;
    int gap;
    wait_valid(gap);
    if (!squelch) acc_m = acc_m + 24'($rtoi(real'(model_hz()) * 16777216.0 * 46.0 / 3579545.0 + 0.5));
  endtask

  task automatic t_phase_cont;
    std_v21 = 1'b0; orig = 1'b1;
    for (int b = 0; b < 10; b++) begin
      tx_data = b[0] ^ b[2];
      run_samples(3, "R4 bit toggling", 1'b1);
    end
  endtask

  task automatic t_echo;
    echo = 1'b1;
    std_v21 = 1'b1; orig = 1'b1; tx_data = 1'b0;
    run_samples(10, "R5 echo v21", 1'b1);
    orig = 1'b0; tx_data = 1'b1;
    run_samples(10, "R5 echo v21 other role", 1'b1);
    std_v21 = 1'b0;
    run_samples(10, "R5 echo bell", 1'b1);
    echo = 1'b0;
  endtask

  task automatic t_squelch;
    std_v21 = 1'b0; orig = 1'b0; tx_data = 1'b0;
    squelch = 1'b1;
    run_samples(8, "R6 squelch", 1'b1);
    squelch = 1'b0;
    run_samples(8, "R6 resume phase", 1'b1);
  endtask

  task automatic t_loop;
    loopback = 1'b1; echo = 1'b1;
    std_v21 = 1'b1; orig = 1'b1; tx_data = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 rx pair own channel orig", rx_ch1, 1);
    wait_valid_sync();
    run_samples(8, "R8 loop tx over echo", 1'b1);
    orig = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 rx pair own channel answer", rx_ch1, 0);
    wait_valid_sync();
    run_samples(6, "R8 loop tx answer", 1'b1);
    loopback = 1'b0; echo = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 rx far after loop", rx_ch1, 1);
    wait_valid_sync();
  endtask

  task automatic t_sleep;
    int seen = 0;
    int gap;
    std_v21 = 1'b0; orig = 1'b1; tx_data = 1'b1;
    loopback = 1'b1; squelch = 1'b1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (valid || sample != 0) seen++;
    end
    chk("R9 quiet while asleep", seen, 0);
    loopback = 1'b0; squelch = 1'b0;
    wait_valid(gap);
    chk("R3 R9 first valid after sleep", gap, DIV);
    chk("R9 phase held", sample, model_sine(acc_m[23:16]));
    acc_m = acc_m + 24'($rtoi(real'(model_hz()) * 16777216.0 * 46.0 / 3579545.0 + 0.5));
    run_samples(6, "R9 after wake", 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_table();
    t_phase_cont();
    t_echo();
    t_squelch();
    t_loop();
    t_sleep();
    report();
    $finish;
  end

endmodule